// File: doc/BRIEF.md
# Space-Vector PWM Duty Calculator

This block turns a voltage command given in the rotating reference frame into three normalised phase duty values for a three-phase inverter. Each command has a direct and a quadrature voltage component and the sine and cosine of the rotor angle, and it arrives with a valid strobe. The block first rotates the command into the stationary frame with an inverse Park transform. It then finds which of the six sextants the vector lies in. Finally it computes the on-time fraction for each of the three phase legs, using the symmetric centred pattern in which the zero-vector time is split evenly between the ends of the switching period.

All arithmetic is signed fixed point with `W-1` fractional bits. With the default `W = 16` this is Q1.15. Internal sums carry two guard bits, so an over-modulated command cannot wrap before the final saturation. The datapath has three register stages. Each result appears with a one-cycle valid pulse a fixed three cycles after its command, and the three outputs hold their values until the next result arrives. The caller supplies the sine and cosine. The caller also scales the duties to its own timer period.

Top module: `svpwm_duty_calc`

## Requirements
- R1: The stationary components are alpha = rnd(d·cos) − rnd(q·sin) and beta = rnd(q·cos) + rnd(d·sin). Here rnd(p) = (p + 2^(F−1)) >>> F, with F = W−1 = 15.
- R2: The sextant code is 1·[beta>0] + 2·[B>0] + 4·[C>0]. Here ka = rnd(alpha·28378), hb = beta >>> 1, B = ka − hb and C = −hb − ka. Codes 1 to 6 are valid sextants.
- R3: The timing operands are X = beta, Y = hb + ka and Z = hb − ka. The base is (2^F − t1 − t2) >>> 2, the middle value is base + (t1 >>> 1), and the top value is middle + (t2 >>> 1).
- R4: The operand pair (t1, t2) and the assignment of base/middle/top to the phases (a, b, c) depend on the sextant, as follows:
  - Sextant 1: (Z, Y) → (mid, base, top).
  - Sextant 2: (Y, −X) → (base, top, mid).
  - Sextant 3: (−Z, X) → (base, mid, top).
  - Sextant 4: (−X, Z) → (top, mid, base).
  - Sextant 5: (X, −Y) → (top, base, mid).
  - Sextant 6: (−Y, −Z) → (mid, top, base).
- R5: Sextant codes 0 and 7 give 16384 (0.5) on all three duties. A zero command (d = q = 0) is one such case.
- R6: Each duty saturates to the range 0 to 2^F − 1 = 32767. Negative values become 0.
- R7: `duty_valid` pulses for one cycle exactly three clock edges after each edge that samples `cmd_valid` high. No other pulse occurs.
- R8: While `duty_valid` is low, all three duty outputs keep their previous values.
- R9: During synchronous reset (`rst_n` low), `duty_valid` is 0 and all three duties are 16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command inputs are valid this cycle |
| v_d | input | W | Direct-axis voltage command, signed Q1.(W−1) |
| v_q | input | W | Quadrature-axis voltage command, signed Q1.(W−1) |
| ang_sin | input | W | Sine of the rotor angle, signed Q1.(W−1) |
| ang_cos | input | W | Cosine of the rotor angle, signed Q1.(W−1) |
| duty_valid | output | 1 | One-cycle pulse marking a new result |
| duty_a | output | W | Phase A duty, 0 to 2^(W−1)−1 |
| duty_b | output | W | Phase B duty, 0 to 2^(W−1)−1 |
| duty_c | output | W | Phase C duty, 0 to 2^(W−1)−1 |

## Verification
Each fault shows up in the result of the command that triggers it, three cycles after that command. A wrong sextant decode or a swapped row in the ordering table puts the base, middle and top values on the wrong phases. That is visible in a single result for any vector in the affected sextant. A bad rounding constant or shift moves the duties by a few codes, so the bench compares every result exactly, without tolerance. A stall, an extra or a missing stage in the valid pipeline breaks the three-cycle alignment, or produces a pulse with no matching command. A sweep over magnitude and angle reaches all six sextants, the zero command and the over-modulated region where saturation applies.

// File: rtl/svpwm_pkg.sv
// Package: shared definitions for the space-vector duty calculator.
// Assumes the sextant code is three bits wide, one bit per reference sign.
package svpwm_pkg;
    typedef logic [2:0] sext_t;
    localparam sext_t SEXT_NULL = 3'd0;
    localparam sext_t SEXT_FULL = 3'd7;
endpackage

// File: rtl/svpwm_inv_park.sv
// Stage 1: inverse Park rotation of the (d, q) command into (alpha, beta).
// Assumes signed inputs with W-1 fractional bits. Outputs are IW bits wide
// with the same fractional scale, so a magnitude up to sqrt(2) fits.
module svpwm_inv_park #(
    parameter int W  = 16,
    parameter int IW = W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  d_in,
    input  logic signed [W-1:0]  q_in,
    input  logic signed [W-1:0]  sin_in,
    input  logic signed [W-1:0]  cos_in,
    output logic                 out_valid,
    output logic signed [IW-1:0] alpha,
    output logic signed [IW-1:0] beta
);
    localparam int FRAC = W - 1;
    localparam int PW   = 2 * W;
    localparam logic signed [PW-1:0] RND = PW'(longint'(1) << (FRAC - 1));

    logic signed [PW-1:0] p_dc, p_qs, p_qc, p_ds;
    logic signed [PW-1:0] r_dc, r_qs, r_qc, r_ds;
    logic signed [IW-1:0] alpha_n, beta_n;

    // Full-precision products, then round-half-up back to the input scale.
    always_comb begin
        p_dc = PW'(d_in) * PW'(cos_in);
        p_qs = PW'(q_in) * PW'(sin_in);
        p_qc = PW'(q_in) * PW'(cos_in);
        p_ds = PW'(d_in) * PW'(sin_in);
        r_dc = (p_dc + RND) >>> FRAC;
        r_qs = (p_qs + RND) >>> FRAC;
        r_qc = (p_qc + RND) >>> FRAC;
        r_ds = (p_ds + RND) >>> FRAC;
        alpha_n = IW'(r_dc) - IW'(r_qs);
        beta_n  = IW'(r_qc) + IW'(r_ds);
    end

    // Register the rotated vector with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            alpha     <= '0;
            beta      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                alpha <= alpha_n;
                beta  <= beta_n;
            end
        end
    end
endmodule

// File: rtl/svpwm_sextant.sv
// Stage 2: projects (alpha, beta) onto three references, forms the sextant
// code from their signs, and registers the X/Y/Z timing operands.
// Assumes alpha/beta use W-1 fractional bits in an IW-bit word.
module svpwm_sextant
    import svpwm_pkg::*;
#(
    parameter int W  = 16,
    parameter int IW = W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [IW-1:0] alpha,
    input  logic signed [IW-1:0] beta,
    output logic                 out_valid,
    output sext_t                sext,
    output logic signed [IW-1:0] op_x,
    output logic signed [IW-1:0] op_y,
    output logic signed [IW-1:0] op_z
);
    localparam int FRAC = W - 1;
    localparam int PW   = IW + W;
    localparam logic signed [PW-1:0] KC  = PW'($rtoi(0.8660254 * (2.0 ** FRAC) + 0.5));
    localparam logic signed [PW-1:0] RND = PW'(longint'(1) << (FRAC - 1));

    logic signed [PW-1:0] p_ka, r_ka;
    logic signed [IW-1:0] ka, hb, ref_b, ref_c;
    sext_t                sext_n;

    // sqrt(3)/2 scaling of alpha, halving of beta, and the sign-weighted code.
    always_comb begin
        p_ka   = PW'(alpha) * KC;
        r_ka   = (p_ka + RND) >>> FRAC;
        ka     = IW'(r_ka);
        hb     = beta >>> 1;
        ref_b  = ka - hb;
        ref_c  = -hb - ka;
        sext_n = {ref_c > 0, ref_b > 0, beta > 0};
    end

    // Register the code and the three timing operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sext      <= SEXT_NULL;
            op_x      <= '0;
            op_y      <= '0;
            op_z      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sext <= sext_n;
                op_x <= beta;
                op_y <= hb + ka;
                op_z <= hb - ka;
            end
        end
    end
endmodule

// File: rtl/svpwm_duty.sv
// Stage 3: picks the sextant's operand pair, builds the base/mid/top chain,
// routes it to the phases, saturates, and holds the result.
// Assumes operands use W-1 fractional bits. Two extra bits absorb the chain.
module svpwm_duty
    import svpwm_pkg::*;
#(
    parameter int W  = 16,
    parameter int IW = W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  sext_t                sext,
    input  logic signed [IW-1:0] op_x,
    input  logic signed [IW-1:0] op_y,
    input  logic signed [IW-1:0] op_z,
    output logic                 out_valid,
    output logic [W-1:0]         duty_a,
    output logic [W-1:0]         duty_b,
    output logic [W-1:0]         duty_c
);
    localparam int FRAC = W - 1;
    localparam int SW   = IW + 2;
    localparam logic signed [SW-1:0] ONE  = SW'(longint'(1) << FRAC);
    localparam logic signed [SW-1:0] HALF = SW'(longint'(1) << (FRAC - 1));
    localparam logic signed [SW-1:0] MAXD = ONE - SW'(1);

    logic signed [SW-1:0] sx, sy, sz, t1, t2, base, mid, top, ta, tb, tc;

    // Clamp a chained value into the unsigned duty range.
    function automatic logic [W-1:0] clamp(input logic signed [SW-1:0] v);
        if (v < 0)         return '0;
        else if (v > MAXD) return W'(MAXD);
        else               return W'(v);
    endfunction

    // Operand selection per sextant, then base/mid/top routing to phases.
    always_comb begin
        sx = SW'(op_x);
        sy = SW'(op_y);
        sz = SW'(op_z);
        unique case (sext)
            3'd1:    begin t1 = sz;  t2 = sy;  end
            3'd2:    begin t1 = sy;  t2 = -sx; end
            3'd3:    begin t1 = -sz; t2 = sx;  end
            3'd4:    begin t1 = -sx; t2 = sz;  end
            3'd5:    begin t1 = sx;  t2 = -sy; end
            3'd6:    begin t1 = -sy; t2 = -sz; end
            default: begin t1 = '0;  t2 = '0;  end
        endcase
        base = (ONE - t1 - t2) >>> 2;
        mid  = base + (t1 >>> 1);
        top  = mid + (t2 >>> 1);
        unique case (sext)
            3'd1:    begin ta = mid;  tb = base; tc = top;  end
            3'd2:    begin ta = base; tb = top;  tc = mid;  end
            3'd3:    begin ta = base; tb = mid;  tc = top;  end
            3'd4:    begin ta = top;  tb = mid;  tc = base; end
            3'd5:    begin ta = top;  tb = base; tc = mid;  end
            3'd6:    begin ta = mid;  tb = top;  tc = base; end
            default: begin ta = HALF; tb = HALF; tc = HALF; end
        endcase
    end

    // Output registers: load on a new result, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            duty_a    <= W'(HALF);
            duty_b    <= W'(HALF);
            duty_c    <= W'(HALF);
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                duty_a <= clamp(ta);
                duty_b <= clamp(tb);
                duty_c <= clamp(tc);
            end
        end
    end
endmodule

// File: rtl/svpwm_duty_calc.sv
// Top: three-stage space-vector duty calculator.
// Stages: inverse Park, sextant decode, then duty chain with saturation.
// Assumes sine/cosine are supplied by the caller in the same Q format.
module svpwm_duty_calc
    import svpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic signed [W-1:0] v_d,
    input  logic signed [W-1:0] v_q,
    input  logic signed [W-1:0] ang_sin,
    input  logic signed [W-1:0] ang_cos,
    output logic                duty_valid,
    output logic [W-1:0]        duty_a,
    output logic [W-1:0]        duty_b,
    output logic [W-1:0]        duty_c
);
    localparam int IW = W + 2;

    logic                 s1_valid, s2_valid;
    logic signed [IW-1:0] s1_alpha, s1_beta;
    logic signed [IW-1:0] s2_x, s2_y, s2_z;
    sext_t                s2_sext;

    svpwm_inv_park #(.W(W), .IW(IW)) park_i (
        .clk(clk), .rst_n(rst_n), .in_valid(cmd_valid),
        .d_in(v_d), .q_in(v_q), .sin_in(ang_sin), .cos_in(ang_cos),
        .out_valid(s1_valid), .alpha(s1_alpha), .beta(s1_beta)
    );

    svpwm_sextant #(.W(W), .IW(IW)) sext_i (
        .clk(clk), .rst_n(rst_n), .in_valid(s1_valid),
        .alpha(s1_alpha), .beta(s1_beta),
        .out_valid(s2_valid), .sext(s2_sext),
        .op_x(s2_x), .op_y(s2_y), .op_z(s2_z)
    );

    svpwm_duty #(.W(W), .IW(IW)) duty_i (
        .clk(clk), .rst_n(rst_n), .in_valid(s2_valid), .sext(s2_sext),
        .op_x(s2_x), .op_y(s2_y), .op_z(s2_z),
        .out_valid(duty_valid), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c)
    );
endmodule

// File: rtl/svpwm_duty_calc_chk.sv
// Checker: port-level timing, hold, range, zero-command and reset properties.
// Assumes the fixed three-edge latency of the top module.
module svpwm_duty_calc_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic signed [W-1:0] v_d,
    input logic signed [W-1:0] v_q,
    input logic                duty_valid,
    input logic [W-1:0]        duty_a,
    input logic [W-1:0]        duty_b,
    input logic [W-1:0]        duty_c
);
    localparam logic [W-1:0] HALF = W'(longint'(1) << (W - 2));
    localparam logic [W-1:0] MAXD = W'((longint'(1) << (W - 1)) - 1);

    logic [2:0] since_rst;

    // Count edges since reset release, saturating at 4.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 4) since_rst <= since_rst + 3'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3) |-> (duty_valid == $past(cmd_valid, 3))); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 1) && !duty_valid) |->
        ($stable(duty_a) && $stable(duty_b) && $stable(duty_c))); // R8

    AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_a <= MAXD) && (duty_b <= MAXD) && (duty_c <= MAXD)); // R6

    AST_ZERO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3) && $past(cmd_valid, 3) && $past((v_d == 0) && (v_q == 0), 3)) |->
        ((duty_a == HALF) && (duty_b == HALF) && (duty_c == HALF))); // R5

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!duty_valid && (duty_a == HALF) && (duty_b == HALF) && (duty_c == HALF))); // R9
endmodule

bind svpwm_duty_calc svpwm_duty_calc_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .v_d(v_d), .v_q(v_q),
    .duty_valid(duty_valid), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c)
);

// File: tb/svpwm_duty_calc_tb_top.sv
// Bench: sweeps magnitude and angle over a d/q grid, models the arithmetic
// from the requirements, and compares every result with its cycle.
module svpwm_duty_calc_tb_top;
    localparam int  W          = 16;
    localparam int  CLK_PERIOD = 10;
    localparam int  LAT        = 3;
    localparam real PI         = 3.14159265358979;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cmd_valid = 1'b0;
    logic signed [W-1:0] v_d = '0, v_q = '0, ang_sin = '0, ang_cos = '0;
    logic                duty_valid;
    logic [W-1:0]        duty_a, duty_b, duty_c;

    int checks = 0, errors = 0, cyc = 0;
    int exp_a[$], exp_b[$], exp_c[$], exp_cyc[$], exp_sx[$];
    int sext_hits[8];
    int sat_hits = 0;
    bit mon_on = 1'b0, done = 1'b0;
    logic [W-1:0] last_a, last_b, last_c;

    svpwm_duty_calc #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .v_d(v_d), .v_q(v_q), .ang_sin(ang_sin), .ang_cos(ang_cos),
        .duty_valid(duty_valid), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint rnd(input longint p);
        return (p + 16384) >>> 15;
    endfunction

    function automatic int clampv(input longint v);
        if (v < 0) return 0;
        if (v > 32767) return 32767;
        return int'(v);
    endfunction

    // Reference model written from the requirement text (R1..R6).
    task automatic model(input longint d, q, s, c, output int ea, eb, ec, sx);
        longint al, be, ka, hb, rb, rc, x, y, z, t1, t2, bs, md, tp, a, b, cc;
        al = rnd(d * c) - rnd(q * s);          // R1
        be = rnd(q * c) + rnd(d * s);
        ka = rnd(al * 28378);                  // 28378 = round(0.8660254 * 2^15)
        hb = be >>> 1;
        rb = ka - hb;
        rc = -hb - ka;
        sx = (be > 0 ? 1 : 0) + (rb > 0 ? 2 : 0) + (rc > 0 ? 4 : 0);   // R2
        x = be; y = hb + ka; z = hb - ka;      // R3
        case (sx)
            1: begin t1 = z;  t2 = y;  end
            2: begin t1 = y;  t2 = -x; end
            3: begin t1 = -z; t2 = x;  end
            4: begin t1 = -x; t2 = z;  end
            5: begin t1 = x;  t2 = -y; end
            6: begin t1 = -y; t2 = -z; end
            default: begin t1 = 0; t2 = 0; end
        endcase
        bs = (32768 - t1 - t2) >>> 2;
        md = bs + (t1 >>> 1);
        tp = md + (t2 >>> 1);
        case (sx)                              // R4 routing
            1: begin a = md; b = bs; cc = tp; end
            2: begin a = bs; b = tp; cc = md; end
            3: begin a = bs; b = md; cc = tp; end
            4: begin a = tp; b = md; cc = bs; end
            5: begin a = tp; b = bs; cc = md; end
            6: begin a = md; b = tp; cc = bs; end
            default: begin a = 16384; b = 16384; cc = 16384; end   // R5
        endcase
        if (a < 0 || a > 32767 || b < 0 || b > 32767 || cc < 0 || cc > 32767) sat_hits++;
        ea = clampv(a); eb = clampv(b); ec = clampv(cc);   // R6
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Drive one command on a falling edge and queue its expected result.
    task automatic send(input int d, q, s, c);
        int ea, eb, ec, sx;
        @(negedge clk);
        v_d = W'(d); v_q = W'(q); ang_sin = W'(s); ang_cos = W'(c);
        cmd_valid = 1'b1;
        model(d, q, s, c, ea, eb, ec, sx);
        exp_a.push_back(ea); exp_b.push_back(eb); exp_c.push_back(ec);
        exp_sx.push_back(sx);
        exp_cyc.push_back(cyc + LAT);
        sext_hits[sx]++;
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0;
        v_d = W'(12345); v_q = W'(-2222);   // junk on idle inputs must not matter (R8)
    endtask

    // Monitor on the falling edge: results, latency and hold behaviour.
    always @(negedge clk) begin
        if (mon_on) begin
            if (duty_valid) begin
                if (exp_a.size() == 0) begin
                    check(1'b0, "R7 unexpected duty_valid", 1, 0);
                end else begin
                    int ea, eb, ec, ecy, sx;
                    ea = exp_a.pop_front(); eb = exp_b.pop_front(); ec = exp_c.pop_front();
                    ecy = exp_cyc.pop_front(); sx = exp_sx.pop_front();
                    check(cyc == ecy, "R7 latency cycle", cyc, ecy);
                    if (sx == 0 || sx == 7) begin
                        check(int'(duty_a) == ea, "R5 duty_a", int'(duty_a), ea);
                        check(int'(duty_b) == eb, "R5 duty_b", int'(duty_b), eb);
                        check(int'(duty_c) == ec, "R5 duty_c", int'(duty_c), ec);
                    end else begin
                        check(int'(duty_a) == ea, "R4 duty_a (R1/R3 datapath)", int'(duty_a), ea);
                        check(int'(duty_b) == eb, "R4 duty_b (R1/R3 datapath)", int'(duty_b), eb);
                        check(int'(duty_c) == ec, "R4 duty_c (R1/R3 datapath)", int'(duty_c), ec);
                    end
                end
            end else begin
                check(duty_a == last_a && duty_b == last_b && duty_c == last_c,
                      "R8 hold duty_a", int'(duty_a), int'(last_a));
            end
            last_a = duty_a; last_b = duty_b; last_c = duty_c;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        real lv[7] = '{-0.95, -0.6, -0.3, 0.0, 0.3, 0.6, 0.95};
        int n = 0;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(duty_valid == 1'b0, "R9 duty_valid in reset", int'(duty_valid), 0);
        check(duty_a == 16384 && duty_b == 16384 && duty_c == 16384,
              "R9 duties in reset", int'(duty_a), 16384);
        rst_n = 1'b1;
        last_a = duty_a; last_b = duty_b; last_c = duty_c;
        mon_on = 1'b1;
        // R5: explicit zero commands at two angles
        send(0, 0, 23170, 23170);
        send(0, 0, -32767, 0);
        idle(); idle();
        // Grid sweep over d, q and 16 angles, with periodic bubbles
        for (int ia = 0; ia < 16; ia++) begin
            real th;
            int s, c;
            th = 2.0 * PI * ia / 16.0 + 0.1;
            s = $rtoi($sin(th) * 32767.0);
            c = $rtoi($cos(th) * 32767.0);
            for (int id = 0; id < 7; id++) begin
                for (int iq = 0; iq < 7; iq++) begin
                    send($rtoi(lv[id] * 32767.0), $rtoi(lv[iq] * 32767.0), s, c);
                    n++;
                    if (n % 5 == 0) idle();
                    if (n % 17 == 0) begin idle(); idle(); idle(); idle(); end
                end
            end
        end
        idle();
        repeat (LAT + 3) @(negedge clk);
        check(exp_a.size() == 0, "R7 all results delivered", exp_a.size(), 0);
        for (int k = 1; k <= 6; k++)
            check(sext_hits[k] > 0, "R2 sextant reached", sext_hits[k], 1);
        check(sat_hits > 0, "R6 saturation exercised", sat_hits, 1);
        finish_run();
    end
endmodule